// File: doc/BRIEF.md
# Comma-Aligned Word Deserializer

This block sits behind a clock-and-data-recovery front end. It takes one retimed bit per bit-clock cycle and rebuilds 10-bit code words from them. It watches the stream for the positive-disparity comma and moves its word boundary onto it. Finished words are presented on two byte clocks. Each byte clock runs at half the word rate, and the two are in opposite phase. Successive words are launched on rising edges of the two clocks in turn, so a downstream protocol engine can capture them with either clock.

When the boundary has to move, the block never produces a short byte-clock phase. It holds the current phase longer and gives up the misaligned comma word. The first comma of the next ordered set is then launched on a rising edge of byte clock 1. A sync enable turns realignment on and off. A sync flag marks the word period of every comma word launched while the enable is high. A signal-detect input forces the word output to all ones while the line carries no signal.

Top module: `comma_deser`

## Requirements
- R1: The first bit received in a word appears at `rx_word[0]`, and later bits fill the higher bit positions in the order they arrive.
- R2: A comma is a word whose bits 0 to 6 are 0,0,1,1,1,1,1, whatever bits 7 to 9 hold. A word that differs from this in any of bits 0 to 6 causes no realignment and no flag.
- R3: Every new word is launched together with a rising edge of exactly one byte clock, and the other byte clock falls on the same edge. The two clocks are never high together. Launches alternate between `bclk1` and `bclk0`. Between launches, `rx_word` and both clocks hold their values.
- R4: Two launches are always at least 10 bit-clock cycles apart, so no byte-clock phase is ever shorter than one word.
- R5: A comma that ends off the current boundary while sync is enabled moves the boundary to that comma. The comma word is dropped, and one extra word is dropped when this is needed so that the next comma, two words later, is launched on a `bclk1` rising edge. After that, words are launched in stream order.
- R6: `sync_flag` is high for the word period of a launched comma word, and only when `sync_en` was high at that launch.
- R7: With `sync_en` low, the boundary never moves, words are the plain 10-bit slices counted from reset, and `sync_flag` stays low.
- R8: While `sig_ok` is low, `rx_word` reads 10'h3FF from the next bit clock on, and a word launched during that time is 10'h3FF.
- R9: After reset, both byte clocks and `sync_flag` are low, and the first launch, 10 bit clocks after reset, goes out on `bclk1`.
- R10: A comma that ends exactly on the current boundary leaves the boundary and the clock sequence unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_in | input | 1 | Retimed serial bit |
| sync_en | input | 1 | Enables comma realignment and the sync flag |
| sig_ok | input | 1 | Signal detected; low forces the word output to all ones |
| rx_word | output | 10 | Rebuilt word, bit 0 first received |
| bclk0 | output | 1 | Byte clock 0 (half word rate) |
| bclk1 | output | 1 | Byte clock 1, opposite phase to byte clock 0 |
| sync_flag | output | 1 | High during the word period of a launched comma |

## Verification
The comma stream is preceded by every bit offset from 0 to 19 except 10. This covers the aligned case, realignment while `bclk1` is high (one dropped word) and realignment while `bclk0` is high (two dropped words), and each case is checked for word order, clock lane and minimum launch spacing. Streams with sync disabled, and streams that carry near-miss patterns with one prefix bit wrong, are compared with plain 10-bit slices of the sent bits. These runs separate wrong bit order and wrong pattern matching from wrong realignment. A signal-loss window in the middle of the stream shows squelch both on the held word and on a word launched during the loss.

// File: rtl/cd_pkg.sv
package cd_pkg;
  localparam int unsigned CD_WORD_W = 10;
  localparam int unsigned CD_MARK_W = 7;
  // bit 0 is the first received bit: 0,0,1,1,1,1,1
  localparam logic [CD_MARK_W-1:0] CD_MARK = 7'b1111100;

  typedef enum logic {LANE0 = 1'b0, LANE1 = 1'b1} lane_e;

  function automatic lane_e other_lane(input lane_e l);
    return (l == LANE1) ? LANE0 : LANE1;
  endfunction
endpackage

// File: rtl/cd_window.sv
module cd_window #(
  parameter int unsigned W      = 10,
  parameter int unsigned MW     = 7,
  parameter logic [MW-1:0] MARK = 7'b1111100
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_in,
  output logic [W-1:0] win,
  output logic         hit
);
  logic [W-1:0] sh;

  // window including the bit arriving at this edge; newest bit at the top
  assign win = {bit_in, sh[W-1:1]};
  assign hit = (win[MW-1:0] == MARK);

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= win;
  end
endmodule

// File: rtl/cd_framer.sv
module cd_framer #(
  parameter int unsigned W = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic sync_en,
  input  logic nxt_is_b1,
  output logic launch,
  output logic realign
);
  localparam int unsigned CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt;
  logic          skip;
  logic          at_edge;

  assign at_edge = (cnt == LAST);
  assign realign = hit && sync_en && !at_edge;
  assign launch  = at_edge && !skip;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      skip <= 1'b0;
    end else if (realign) begin
      cnt  <= '0;
      // drop one more boundary when the next launch would hit the wrong lane
      skip <= nxt_is_b1;
    end else if (at_edge) begin
      cnt  <= '0;
      skip <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/cd_launcher.sv
module cd_launcher #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         launch,
  input  logic [W-1:0] win,
  input  logic         hit,
  input  logic         sync_en,
  input  logic         sig_ok,
  output logic [W-1:0] word_q,
  output logic         bclk0,
  output logic         bclk1,
  output logic         flag,
  output logic         nxt_is_b1
);
  import cd_pkg::*;

  lane_e nxt;
  assign nxt_is_b1 = (nxt == LANE1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '1;
      bclk0  <= 1'b0;
      bclk1  <= 1'b0;
      flag   <= 1'b0;
      nxt    <= LANE1;
    end else if (launch) begin
      word_q <= sig_ok ? win : '1;
      bclk1  <= (nxt == LANE1);
      bclk0  <= (nxt == LANE0);
      flag   <= hit && sync_en;
      nxt    <= other_lane(nxt);
    end else if (!sig_ok) begin
      word_q <= '1;
    end
  end
endmodule

// File: rtl/comma_deser.sv
module comma_deser #(
  parameter int unsigned WORD_W = cd_pkg::CD_WORD_W,
  parameter int unsigned MARK_W = cd_pkg::CD_MARK_W,
  parameter logic [MARK_W-1:0] MARK = cd_pkg::CD_MARK
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_in,
  input  logic              sync_en,
  input  logic              sig_ok,
  output logic [WORD_W-1:0] rx_word,
  output logic              bclk0,
  output logic              bclk1,
  output logic              sync_flag
);
  logic [WORD_W-1:0] win_w;
  logic              hit_w;
  logic              launch_w;
  logic              realign_w;
  logic              nxt_b1_w;

  cd_window #(.W(WORD_W), .MW(MARK_W), .MARK(MARK)) u_win (
    .clk(clk), .rst_n(rst_n), .bit_in(ser_in), .win(win_w), .hit(hit_w)
  );

  cd_framer #(.W(WORD_W)) u_frm (
    .clk(clk), .rst_n(rst_n), .hit(hit_w), .sync_en(sync_en),
    .nxt_is_b1(nxt_b1_w), .launch(launch_w), .realign(realign_w)
  );

  cd_launcher #(.W(WORD_W)) u_lau (
    .clk(clk), .rst_n(rst_n), .launch(launch_w), .win(win_w), .hit(hit_w),
    .sync_en(sync_en), .sig_ok(sig_ok), .word_q(rx_word), .bclk0(bclk0),
    .bclk1(bclk1), .flag(sync_flag), .nxt_is_b1(nxt_b1_w)
  );
endmodule

// File: rtl/cd_checker.sv
module cd_checker #(
  parameter int unsigned W = 10
) (
  input logic         clk,
  input logic         rst_n,
  input logic         sig_ok,
  input logic         sync_en,
  input logic         launch,
  input logic [W-1:0] rx_word,
  input logic         bclk0,
  input logic         bclk1,
  input logic         sync_flag
);
  localparam int unsigned GW = $clog2(W + 1);

  logic [GW-1:0] gap;
  logic          started;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap     <= '0;
      started <= 1'b0;
    end else if (launch) begin
      gap     <= '0;
      started <= 1'b1;
    end else if (gap < GW'(W)) begin
      gap <= gap + 1'b1;
    end
  end

  AST_ONE_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bclk0, bclk1})); // R3

  AST_LAUNCH_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (bclk0 != bclk1) && ($rose(bclk0) || $rose(bclk1))); // R3

  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!launch && sig_ok) |=> $stable(rx_word) && $stable(bclk0) && $stable(bclk1)); // R3

  AST_NO_SHORT_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && started) |-> (gap >= GW'(W - 1))); // R4

  AST_FLAG_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_flag) |-> $past(sync_en)); // R6

  AST_SQUELCH: assert property (@(posedge clk) disable iff (!rst_n)
    !sig_ok |=> (rx_word == {W{1'b1}})); // R8
endmodule

bind comma_deser cd_checker #(.W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sig_ok(sig_ok), .sync_en(sync_en),
  .launch(launch_w), .rx_word(rx_word), .bclk0(bclk0), .bclk1(bclk1),
  .sync_flag(sync_flag)
);

// File: tb/sim_comma_deser.sv
module sim_comma_deser;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_in = 1'b0;
  logic sync_en = 1'b1;
  logic sig_ok = 1'b1;
  logic [9:0] rx_word;
  logic bclk0, bclk1, sync_flag;

  comma_deser u0 (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .sync_en(sync_en),
    .sig_ok(sig_ok), .rx_word(rx_word), .bclk0(bclk0), .bclk1(bclk1),
    .sync_flag(sync_flag)
  );

  always #(CLK_P/2) clk = ~clk;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // launch monitor
  logic [9:0] lw [0:63];
  logic       lc1 [0:63];
  logic       lf [0:63];
  int nl = 0;
  int gap = 0;
  int viol = 0;
  logic pb0 = 1'b0, pb1 = 1'b0;

  // sent bits since reset
  logic sent [0:1023];
  int nbits = 0;

  logic [9:0] stream [0:13];

  always @(negedge clk) begin
    gap = gap + 1;
    if ((bclk0 && !pb0) || (bclk1 && !pb1)) begin
      if (nl > 0 && gap < 10) viol = viol + 1;
      if (nl < 64) begin
        lw[nl] = rx_word; lc1[nl] = bclk1; lf[nl] = sync_flag;
      end
      nl = nl + 1;
      gap = 0;
    end
    pb0 = bclk0; pb1 = bclk1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    ser_in = b;
    if (nbits < 1024) sent[nbits] = b;
    nbits++;
    @(negedge clk);
  endtask

  task automatic send_word(input logic [9:0] w);
    for (int i = 0; i < 10; i++) send_bit(w[i]);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ser_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    nl = 0; gap = 0; viol = 0; nbits = 0;
    // R9: reset state
    chk(!bclk0 && !bclk1 && !sync_flag, "R9 reset state",
        {bclk0, bclk1, sync_flag}, 0);
  endtask

  function automatic logic [9:0] mk_data(input int k);
    return 10'((k * 37 + 11) & 10'h3FF) & 10'b1101101101;
  endfunction

  function automatic logic [9:0] mk_comma(input int k);
    return {3'(k), 7'b1111100};
  endfunction

  function automatic logic [9:0] slice(input int k);
    logic [9:0] r;
    for (int i = 0; i < 10; i++) r[i] = sent[10 * k + i];
    return r;
  endfunction

  task automatic build_stream();
    for (int j = 0; j < 14; j++)
      stream[j] = (j < 12 && j % 2 == 0) ? mk_comma(j / 2) : mk_data(j);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    build_stream();

    // offset sweep with sync enabled: R5, R10, R4, R6, R3
    for (int off = 0; off < 20; off++) begin
      if (off == 10) continue;
      sync_en = 1'b1; sig_ok = 1'b1;
      do_reset();
      for (int i = 0; i < off; i++) send_bit(1'b0);
      for (int j = 0; j < 14; j++) send_word(stream[j]);
      for (int j = 0; j < 3; j++) send_word(10'h000);
      begin
        int g, f;
        g = (off == 0) ? 0 : (off + 9) / 10;
        f = (off == 0) ? 0 : ((g % 2 == 1) ? 1 : 2);
        chk(nl >= g + 14 - f, "R5 launch count", nl, g + 14 - f);
        for (int j = f; j < 14; j++) begin
          int l;
          l = g + j - f;
          if (l < nl && l < 64) begin
            chk(lw[l] == stream[j], (off == 0) ? "R10 word" : "R5 word", lw[l], stream[j]);
            chk(lc1[l] == (j % 2 == 0), "R3 lane", lc1[l], (j % 2 == 0));
            chk(lf[l] == (j < 12 && j % 2 == 0), "R6 flag", lf[l], (j < 12 && j % 2 == 0));
          end
        end
        chk(viol == 0, "R4 short phase", viol, 0);
      end
    end

    // sync disabled: plain slices, no flag (R7, R1)
    for (int off = 1; off < 8; off += 3) begin
      sync_en = 1'b0;
      do_reset();
      for (int i = 0; i < off; i++) send_bit(1'b0);
      for (int j = 0; j < 14; j++) send_word(stream[j]);
      send_word(10'h000);
      for (int k = 0; k < 12; k++) begin
        chk(lw[k] == slice(k), "R7 R1 slice", lw[k], slice(k));
        chk(lf[k] == 1'b0, "R7 flag", lf[k], 0);
        chk(lc1[k] == (k % 2 == 0), "R9 R3 lane", lc1[k], (k % 2 == 0));
      end
    end

    // near-miss patterns with sync enabled: no realign (R2)
    sync_en = 1'b1;
    do_reset();
    for (int i = 0; i < 3; i++) send_bit(1'b0);
    for (int j = 0; j < 6; j++) begin
      send_word((j % 2 == 0) ? 10'h13C : 10'h178);
      send_word(mk_data(j));
    end
    send_word(10'h000);
    for (int k = 0; k < 12; k++) begin
      chk(lw[k] == slice(k), "R2 near miss", lw[k], slice(k));
      chk(lf[k] == 1'b0, "R2 flag", lf[k], 0);
    end

    // squelch (R8)
    sync_en = 1'b1; sig_ok = 1'b1;
    do_reset();
    for (int j = 0; j < 4; j++) send_word(stream[j]);
    sig_ok = 1'b0;
    send_bit(stream[4][0]);
    chk(rx_word == 10'h3FF, "R8 squelch held", rx_word, 10'h3FF);
    for (int i = 1; i < 10; i++) send_bit(stream[4][i]);
    sig_ok = 1'b1;
    for (int j = 5; j < 8; j++) send_word(stream[j]);
    send_word(10'h000);
    chk(lw[4] == 10'h3FF, "R8 squelch launch", lw[4], 10'h3FF);
    chk(lw[5] == stream[5], "R8 recovery", lw[5], stream[5]);
    chk(lw[6] == stream[6] && lc1[6], "R8 recovery comma", lw[6], stream[6]);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule